// File: doc/BRIEF.md
# External Interrupt Arbiter with Claim and Complete

This block collects 32 external interrupt lines for one processor and presents the most urgent one. Each raw line is resynchronized, and a rising edge on it latches a pending bit. Software assigns every source a 3-bit urgency level, turns sources on with a 32-bit mask, and can raise a global cut-off level. Whenever at least one pending, enabled and unclaimed source has a level above the cut-off, a single interrupt output to the processor is high.

The processor's handler reads one register to get the ID of the winning source. That same read marks the source as in service and drops its pending bit. After the handler finishes, it writes the ID back to the same address, which lets the source interrupt again. Line 0 carries no source: its level is always zero and it never wins. All control goes through a simple strobe-qualified register port with a 10-bit byte address, byte selects and a write enable. Read data is combinational.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset every register reads 0, no source is pending or in service, and the interrupt output is low.
- R2: A 0-to-1 transition on a source line sets that source's pending bit on the third rising clock edge after the line changes. A line that simply stays high does not set the bit again after it has been cleared.
- R3: The 3-bit level of source n sits in data bits 2:0 at offset 4*n (0x000 to 0x07C) and is written only when byte select bit 0 is set. Source 0's level always reads 0 and ignores writes. An edge on line 0 never sets pending bit 0.
- R4: The enable mask is at offset 0x100 (bit n enables source n). A write changes only the bytes whose byte-select bits are 1.
- R5: A source is eligible when it is pending, enabled, not in service, and its level is strictly greater than the cut-off level. The cut-off sits in bits 2:0 at offset 0x200 and is written when byte select bit 0 is set. The interrupt output is high exactly when some source is eligible.
- R6: Among eligible sources, the one with the highest level wins. On equal levels the lowest-numbered source wins.
- R7: A strobed read of offset 0x204 returns the winning ID in bits 4:0 and, at that clock edge, clears the winner's pending bit and marks it in service. With no eligible source the read returns 0 and changes nothing.
- R8: A strobed write to offset 0x204 with byte select bit 0 set releases the source whose ID is in data bits 4:0. ID 0, or a write with byte select bit 0 clear, has no effect.
- R9: A rising edge that lands on the same clock as the claim of that source leaves its pending bit set. An edge that arrives while the source is in service sets pending, and the source is presented again once it is released.
- R10: The pending word at offset 0x080 is read-only. Writes to it or to unmapped offsets change nothing. Unmapped or unaligned offsets read 0, and read data is 0 while the strobe is low.
- R11: Only a read (strobe high, write enable low) at 0x204 claims. An unstrobed access at that address does not claim, and neither does a write to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_stb | input | 1 | Register access strobe |
| req_addr | input | 10 | Byte offset of the access |
| req_be | input | 4 | Byte selects for writes |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Combinational read data, 0 when not strobed |
| irq_src | input | 32 | Raw interrupt lines, bit n = source n |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The case that needs the most care is a claim read and a fresh rising edge of the same source landing on one clock edge. Here the clear caused by the claim and the set caused by the edge meet on one pending bit. The bench first leaves a source pending with its line low. It then raises the line and places the claim read exactly two edges later, so that the edge detector fires on the claim's edge. It expects the read to return that ID, the pending word to still show the bit, the output to stay low while the source is in service, and the source to be presented again right after its ID is written back. Random traffic then mixes claims, releases, line changes and register writes against a bench model.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    localparam int unsigned SRC_N  = 32;
    localparam int unsigned PRIO_W = 3;
    localparam int unsigned ADDR_W = 10;
    localparam int unsigned DATA_W = 32;

    // Byte offsets of the register words; software decodes these.
    localparam int unsigned OFS_LEVEL_BASE = 'h000;
    localparam int unsigned OFS_PENDING    = 'h080;
    localparam int unsigned OFS_ENABLE     = 'h100;
    localparam int unsigned OFS_CUTOFF     = 'h200;
    localparam int unsigned OFS_CLAIM      = 'h204;

endpackage

// File: rtl/ext_irq_edge.sv
module ext_irq_edge #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] rise_o
);

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] dly;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d     = sync_q;
        sync_d.s1  = raw_i;
        sync_d.s2  = sync_q.s1;
        sync_d.dly = sync_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign rise_o = sync_q.s2 & ~sync_q.dly;

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R2: an edge pulse lasts exactly one cycle
        assert_rise_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
        // R2: an edge follows a high first-stage sample
        assert_rise_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |-> $past(sync_q.s1[g]));
    end

endmodule

// File: rtl/ext_irq_arb.sv
module ext_irq_arb #(
    parameter int unsigned N  = 32,
    parameter int unsigned PW = 3,
    parameter int unsigned IW = 5
) (
    input  logic [N-1:0]         cand_i,
    input  logic [N-1:0][PW-1:0] level_i,
    input  logic [PW-1:0]        cutoff_i,
    output logic                 valid_o,
    output logic [IW-1:0]        win_id_o,
    output logic [PW-1:0]        win_level_o
);

    // Running best starts at the cut-off, so only strictly higher levels
    // can win, and a later equal level never displaces an earlier one.
    always_comb begin
        valid_o     = 1'b0;
        win_id_o    = '0;
        win_level_o = cutoff_i;
        for (int i = 1; i < int'(N); i++) begin
            if (cand_i[i] && (level_i[i] > win_level_o)) begin
                valid_o     = 1'b1;
                win_id_o    = IW'(i);
                win_level_o = level_i[i];
            end
        end
    end

    always_comb begin
        // R5: a reported winner is a candidate above the cut-off
        assert_win_eligible_R5: assert (!valid_o ||
            (cand_i[win_id_o] && (level_i[win_id_o] > cutoff_i) && (win_id_o != '0)));
        for (int j = 1; j < int'(N); j++) begin
            // R6: no candidate outranks the winner, no earlier one ties it
            assert_win_highest_R6: assert (!(valid_o && cand_i[j] &&
                ((level_i[j] > level_i[win_id_o]) ||
                 ((level_i[j] == level_i[win_id_o]) && (IW'(j) < win_id_o)))));
        end
    end

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int unsigned N_SRC   = ext_irq_pkg::SRC_N,
    parameter int unsigned LVL_W   = ext_irq_pkg::PRIO_W,
    parameter int unsigned A_W     = ext_irq_pkg::ADDR_W,
    parameter int unsigned D_W     = ext_irq_pkg::DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_stb,
    input  logic [A_W-1:0]   req_addr,
    input  logic [D_W/8-1:0] req_be,
    input  logic             req_we,
    input  logic [D_W-1:0]   req_wdata,
    output logic [D_W-1:0]   rsp_rdata,
    input  logic [N_SRC-1:0] irq_src,
    output logic             irq_out
);

    localparam int unsigned ID_W     = $clog2(N_SRC);
    localparam int unsigned LVL_SPAN = N_SRC * 4;

    typedef struct packed {
        logic [N_SRC-1:0][LVL_W-1:0] level;
        logic [N_SRC-1:0]            en;
        logic [N_SRC-1:0]            pend;
        logic [N_SRC-1:0]            busy;
        logic [LVL_W-1:0]            cutoff;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic [N_SRC-1:0] rise;
    logic [N_SRC-1:0] cand;
    logic             win_valid;
    logic [ID_W-1:0]  win_id;
    logic [LVL_W-1:0] win_level;

    logic             do_wr, do_rd;
    logic             hit_level, hit_pend, hit_en, hit_cut, hit_claim;
    logic [ID_W-1:0]  lvl_idx;
    logic [ID_W-1:0]  done_id;
    logic             done_ok;
    logic             claim_fire, done_fire;

    ext_irq_edge #(.N(N_SRC)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_src),
        .rise_o (rise)
    );

    assign cand = st_q.pend & st_q.en & ~st_q.busy;

    ext_irq_arb #(.N(N_SRC), .PW(LVL_W), .IW(ID_W)) u_arb (
        .cand_i      (cand),
        .level_i     (st_q.level),
        .cutoff_i    (st_q.cutoff),
        .valid_o     (win_valid),
        .win_id_o    (win_id),
        .win_level_o (win_level)
    );

    // Address decode: only aligned words are mapped.
    assign do_wr     = req_stb &  req_we;
    assign do_rd     = req_stb & ~req_we;
    assign hit_level = (req_addr < A_W'(LVL_SPAN)) && (req_addr[1:0] == 2'b00);
    assign hit_pend  = (req_addr == A_W'(OFS_PENDING));
    assign hit_en    = (req_addr == A_W'(OFS_ENABLE));
    assign hit_cut   = (req_addr == A_W'(OFS_CUTOFF));
    assign hit_claim = (req_addr == A_W'(OFS_CLAIM));
    assign lvl_idx   = req_addr[ID_W+1:2];
    assign done_id   = req_wdata[ID_W-1:0];

    if (N_SRC == (1 << ID_W)) begin : g_id_full
        assign done_ok = (done_id != '0);
    end else begin : g_id_part
        assign done_ok = (done_id != '0) && ({1'b0, done_id} < (ID_W+1)'(N_SRC));
    end

    assign claim_fire = do_rd & hit_claim & win_valid;
    assign done_fire  = do_wr & hit_claim & req_be[0] & done_ok;

    always_comb begin
        st_d = st_q;

        if (do_wr && hit_level && req_be[0] && (lvl_idx != '0)) begin
            st_d.level[lvl_idx] = req_wdata[LVL_W-1:0];
        end

        if (do_wr && hit_en) begin
            for (int i = 0; i < int'(N_SRC); i++) begin
                if (req_be[i/8]) st_d.en[i] = req_wdata[i];
            end
        end

        if (do_wr && hit_cut && req_be[0]) begin
            st_d.cutoff = req_wdata[LVL_W-1:0];
        end

        if (done_fire) begin
            st_d.busy[done_id] = 1'b0;
        end

        if (claim_fire) begin
            st_d.pend[win_id] = 1'b0;
            st_d.busy[win_id] = 1'b1;
        end

        // A fresh edge wins over a same-cycle claim clear.
        st_d.pend    = st_d.pend | rise;
        st_d.pend[0] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rsp_rdata = '0;
        if (do_rd) begin
            if (hit_level)      rsp_rdata = D_W'(st_q.level[lvl_idx]);
            else if (hit_pend)  rsp_rdata = D_W'(st_q.pend);
            else if (hit_en)    rsp_rdata = D_W'(st_q.en);
            else if (hit_cut)   rsp_rdata = D_W'(st_q.cutoff);
            else if (hit_claim) rsp_rdata = win_valid ? D_W'(win_id) : '0;
        end
    end

    assign irq_out = win_valid;

    // R7: a claimed winner is in service on the next cycle
    assert_claim_marks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> st_q.busy[$past(win_id)]);
    // R7: a claim read with nothing eligible leaves service state alone
    assert_claim_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && hit_claim && !win_valid) |=> (st_q.busy == $past(st_q.busy)));
    // R8: a release frees the named source
    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_fire |=> !st_q.busy[$past(done_id)]);
    // R5: the request output implies some pending, enabled, free source
    assert_irq_eligible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((st_q.pend & st_q.en & ~st_q.busy) != '0));
    // R9: every detected edge on a real source is pending afterwards
    assert_edge_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise >> 1) != '0) |=> ((st_q.pend & $past(rise)) >> 1) == ($past(rise) >> 1));
    // R11: a write to the claim offset never marks anything in service
    assert_write_no_claim_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && hit_claim) |=> ((st_q.busy & ~$past(st_q.busy)) == '0));
    // R10: read data is quiet without a strobe
    assert_idle_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_stb |-> (rsp_rdata == '0));

endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_stb;
    logic [9:0]  req_addr;
    logic [3:0]  req_be;
    logic        req_we;
    logic [31:0] req_wdata;
    logic [31:0] rsp_rdata;
    logic [31:0] irq_src;
    logic        irq_out;

    int n_chk  = 0;
    int n_fail = 0;

    bit [2:0]  m_lvl [NS];
    bit [31:0] m_en, m_pend, m_busy, m_lines;
    bit [2:0]  m_cut;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_stb   (req_stb),
        .req_addr  (req_addr),
        .req_be    (req_be),
        .req_we    (req_we),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .irq_src   (irq_src),
        .irq_out   (irq_out)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_winner();
        int id = 0;
        bit [2:0] best = m_cut;
        for (int i = 1; i < NS; i++) begin
            if (m_pend[i] && m_en[i] && !m_busy[i] && (m_lvl[i] > best)) begin
                best = m_lvl[i];
                id = i;
            end
        end
        return id;
    endfunction

    function automatic bit [31:0] m_read(bit [9:0] a);
        if (a < 10'h080 && a[1:0] == 2'b00) return 32'(m_lvl[a[6:2]]);
        if (a == 10'h080) return m_pend;
        if (a == 10'h100) return m_en;
        if (a == 10'h200) return 32'(m_cut);
        if (a == 10'h204) return 32'(m_winner());
        return 32'h0;
    endfunction

    function automatic void m_write(bit [9:0] a, bit [31:0] d, bit [3:0] be);
        if (a < 10'h080 && a[1:0] == 2'b00 && a[6:2] != 0 && be[0]) m_lvl[a[6:2]] = d[2:0];
        if (a == 10'h100) begin
            for (int b = 0; b < 4; b++) if (be[b]) m_en[b*8 +: 8] = d[b*8 +: 8];
        end
        if (a == 10'h200 && be[0]) m_cut = d[2:0];
        if (a == 10'h204 && be[0] && d[4:0] != 0) m_busy[d[4:0]] = 1'b0;
    endfunction

    task automatic bus_wr(bit [9:0] a, bit [31:0] d, bit [3:0] be);
        @(negedge clk);
        req_stb = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_stb = 1'b0; req_we = 1'b0;
        m_write(a, d, be);
    endtask

    task automatic bus_rd(bit [9:0] a, string req);
        bit [31:0] exp;
        int w;
        @(negedge clk);
        req_stb = 1'b1; req_we = 1'b0; req_addr = a; req_be = 4'hF;
        #(CLK_PERIOD/4);
        exp = m_read(a);
        chk(req, rsp_rdata, exp);
        if (a == 10'h204) begin
            w = m_winner();
            if (w != 0) begin
                m_pend[w] = 1'b0;
                m_busy[w] = 1'b1;
            end
        end
        @(negedge clk);
        req_stb = 1'b0;
    endtask

    task automatic set_lines(bit [31:0] v);
        @(negedge clk);
        irq_src = v;
        repeat (4) @(negedge clk);
        m_pend = m_pend | (v & ~m_lines & 32'hFFFF_FFFE);
        m_lines = v;
    endtask

    task automatic chk_irq(string req);
        chk(req, 32'(irq_out), 32'(m_winner() != 0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        int unsigned seed;
        rst_n = 1'b0; req_stb = 1'b0; req_we = 1'b0; req_addr = '0;
        req_be = '0; req_wdata = '0; irq_src = '0;
        m_en = 0; m_pend = 0; m_busy = 0; m_lines = 0; m_cut = 0;
        for (int i = 0; i < NS; i++) m_lvl[i] = 0;
        seed = 32'd20240611;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 32'(irq_out), 32'h0);
        bus_rd(10'h080, "R1 pending");
        bus_rd(10'h100, "R1 enable");
        bus_rd(10'h200, "R1 cutoff");
        bus_rd(10'h014, "R1 level5");
        bus_rd(10'h204, "R1 claim");

        // R4: byte-selected enable write
        bus_wr(10'h100, 32'hFFFF_FFFF, 4'b0101);
        bus_rd(10'h100, "R4 enable bytes");
        bus_wr(10'h100, 32'h0000_0000, 4'b1111);

        // R3: source 0 level and line ignored
        bus_wr(10'h000, 32'h7, 4'hF);
        bus_rd(10'h000, "R3 level0");
        bus_wr(10'h01C, 32'h5, 4'b1110);
        bus_rd(10'h01C, "R3 be0 clear");
        set_lines(32'h0000_0001);
        set_lines(32'h0);
        bus_rd(10'h080, "R3 pending0");

        // R5: strict threshold
        bus_wr(10'h010, 32'h4, 4'h1);
        bus_wr(10'h100, 32'h0000_0010, 4'hF);
        set_lines(32'h0000_0010);
        set_lines(32'h0);
        bus_rd(10'h080, "R2 pending4");
        bus_wr(10'h200, 32'h4, 4'h1);
        chk("R5 cutoff equal", 32'(irq_out), 32'h0);
        bus_wr(10'h200, 32'h3, 4'h1);
        chk("R5 cutoff below", 32'(irq_out), 32'h1);

        // R2: a held-high line does not re-arm after claim
        set_lines(32'h0000_0010);
        bus_rd(10'h204, "R7 claim4");
        bus_wr(10'h204, 32'h4, 4'h1);
        repeat (4) @(negedge clk);
        chk("R2 held line", 32'(irq_out), 32'h0);
        set_lines(32'h0);

        // R6: tie goes to lower ID; R7 claims in order then empty
        bus_wr(10'h024, 32'h6, 4'h1);
        bus_wr(10'h00C, 32'h6, 4'h1);
        bus_wr(10'h100, 32'h0000_0218, 4'hF);
        set_lines(32'h0000_0218);
        set_lines(32'h0);
        bus_rd(10'h204, "R6 tie low id");
        bus_rd(10'h204, "R6 second");
        bus_rd(10'h204, "R7 third");
        bus_rd(10'h204, "R7 empty");
        bus_rd(10'h080, "R7 pending cleared");
        // R8: release ignored without byte 0, then accepted
        bus_wr(10'h204, 32'h3, 4'b1110);
        bus_rd(10'h204, "R8 be0 ignored");
        bus_wr(10'h204, 32'h0, 4'h1);
        bus_wr(10'h204, 32'h3, 4'h1);
        bus_wr(10'h204, 32'h9, 4'h1);
        bus_wr(10'h204, 32'h4, 4'h1);
        chk_irq("R8 all released");

        // R9: edge on the claim cycle
        bus_wr(10'h100, 32'h0000_0080, 4'hF);
        bus_wr(10'h01C, 32'h5, 4'h1);
        bus_wr(10'h200, 32'h0, 4'h1);
        set_lines(32'h0000_0080);
        set_lines(32'h0);
        @(negedge clk);
        irq_src = 32'h0000_0080;
        @(negedge clk);
        @(negedge clk);
        req_stb = 1'b1; req_we = 1'b0; req_addr = 10'h204;
        #(CLK_PERIOD/4);
        chk("R9 claim id", rsp_rdata, 32'd7);
        @(negedge clk);
        req_stb = 1'b0;
        m_busy[7] = 1'b1; m_lines = 32'h0000_0080;
        repeat (3) @(negedge clk);
        bus_rd(10'h080, "R9 pending kept");
        chk("R9 busy holds", 32'(irq_out), 32'h0);
        bus_wr(10'h204, 32'h7, 4'h1);
        chk("R9 presented again", 32'(irq_out), 32'h1);
        bus_rd(10'h204, "R9 reclaim");
        // edge while in service
        set_lines(32'h0);
        set_lines(32'h0000_0080);
        chk("R9 in service", 32'(irq_out), 32'h0);
        bus_wr(10'h204, 32'h7, 4'h1);
        chk("R9 after release", 32'(irq_out), 32'h1);

        // R11: no claim by write or unstrobed access
        bus_wr(10'h204, 32'h0, 4'h1);
        chk("R11 write no claim", 32'(irq_out), 32'h1);
        @(negedge clk);
        req_addr = 10'h204; req_we = 1'b0; req_stb = 1'b0;
        #(CLK_PERIOD/4);
        chk("R10 no strobe data", rsp_rdata, 32'h0);
        @(negedge clk);
        chk("R11 unstrobed", 32'(irq_out), 32'h1);

        // R10: read-only pending and unmapped offsets
        bus_wr(10'h080, 32'hFFFF_FFFF, 4'hF);
        bus_wr(10'h300, 32'hFFFF_FFFF, 4'hF);
        bus_wr(10'h006, 32'h7, 4'hF);
        bus_rd(10'h080, "R10 pending ro");
        bus_rd(10'h300, "R10 unmapped");
        bus_rd(10'h006, "R10 unaligned");
        bus_rd(10'h004, "R10 level1 kept");

        // Random mix
        for (int it = 0; it < 600; it++) begin
            int op;
            bit [9:0] a;
            bit [31:0] d;
            op = $urandom_range(0, 9);
            d = $urandom;
            case (op)
                0, 1: bus_wr(10'($urandom_range(0, 31) * 4), d, 4'($urandom_range(0, 15)));
                2: bus_wr(10'h100, d, 4'($urandom_range(0, 15)));
                3: bus_wr(10'h200, 32'($urandom_range(0, 4)), 4'($urandom_range(0, 15)));
                4: set_lines(m_lines ^ ($urandom & $urandom));
                5, 6: bus_rd(10'h204, "R7 random claim");
                7: begin
                    int id = $urandom_range(0, 31);
                    for (int k = 0; k < NS; k++) begin
                        if (m_busy[(id + k) % NS]) begin
                            id = (id + k) % NS;
                            break;
                        end
                    end
                    bus_wr(10'h204, 32'(id), 4'($urandom_range(0, 15)) | 4'h1);
                end
                8: begin
                    case ($urandom_range(0, 5))
                        0: a = 10'h080;
                        1: a = 10'h100;
                        2: a = 10'h200;
                        3: a = 10'h3FC;
                        4: a = 10'h081;
                        default: a = 10'($urandom_range(0, 31) * 4);
                    endcase
                    bus_rd(a, "R10 random read");
                end
                default: bus_wr(10'($urandom_range(129, 255)) | 10'h100, d, 4'hF);
            endcase
            chk_irq("R5 random irq");
        end

        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule